// File: doc/BRIEF.md
# Banked Interleaved Word Memory Controller

This block is a word-addressed memory built from several independent banks of equal size, behind a single request port. Each request carries a read/write flag, a word address and write data, and is offered with a valid/ready handshake at up to one per clock. The address is split into a bank number and a word offset inside that bank. The split follows one of two mappings chosen by a mode input. In spread mode, neighbouring addresses land in neighbouring banks. In block mode, each bank owns one contiguous slice of the address space.

Every bank is busy for a fixed access time followed by a recovery time after it takes a request. Requests to different banks overlap freely. A request that targets a busy bank waits at the port, and everything behind it waits too. Read data returns on a response strobe, in the order the reads were accepted, through a small queue of bank tags. A free-running counter records the cycles lost to bank conflicts. This makes visible the difference between a linear stream in the two modes.

Top module: `bank_interleave_ctrl`

## Requirements
- R1: With `modeHigh`=0 (spread mode) the bank is `reqAddr[BANK_BITS-1:0]` and the offset is `reqAddr[ADDR_W-1:BANK_BITS]`. The stored word lives at physical slot {bank, offset}, so a word written in spread mode at address a is read back in block mode at address {a[BANK_BITS-1:0], a[ADDR_W-1:BANK_BITS]}.
- R2: With `modeHigh`=1 (block mode) the bank is `reqAddr[ADDR_W-1:ADDR_W-BANK_BITS]` and the offset is the low ADDR_W-BANK_BITS bits. Physical slot {bank, offset} therefore equals the address itself.
- R3: A read accepted at clock edge E drives `rspValid`=1 with its data in the cycle that follows edge E+ACCESS_CYC.
- R4: A bank that accepts a request at edge E accepts its next request no earlier than edge E+ACCESS_CYC+RECOVER_CYC. A back-to-back pair to one bank is accepted exactly that many edges apart.
- R5: Requests to distinct idle banks are accepted on consecutive edges, and a write to a free bank is never refused.
- R6: Requests are accepted strictly in order. While the head request waits for its bank, `reqReady` stays 0, and a later request to a free bank is not accepted ahead of it.
- R7: Each accepted read produces exactly one single-cycle `rspValid` pulse. Pulses come in the order the reads were accepted, and writes produce none.
- R8: The mode input is taken only while no bank is busy and no read is outstanding. A change made while requests are in flight has no effect on the requests accepted in that time.
- R9: `stallCount` increases by one in every cycle where `reqValid`=1 and the target bank is busy, and holds otherwise. A linear stream causes no stalls in spread mode when banks outnumber the busy time. In block mode it costs ACCESS_CYC+RECOVER_CYC-1 stall cycles per beat after the first.
- R10: A write takes effect when its bank access completes, and a later read of the same address returns the new data.
- R11: After reset every bank is free, so `reqReady`=1, `rspValid`=0 and `stallCount`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| modeHigh | input | 1 | 0 = spread (low bits pick bank), 1 = block (high bits pick bank) |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Request can be taken this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Word address |
| reqWdata | input | DATA_W | Write data |
| rspValid | output | 1 | Read data valid, one pulse per read |
| rspData | output | DATA_W | Read data |
| stallCount | output | STALL_W | Cycles spent waiting on a busy bank |

## Verification
The bench builds the block with a 6-bit address, four banks of sixteen 8-bit words, an access time of 2 and a recovery time of 1. A bank's busy span of three cycles is then shorter than the four-bank rotation, so a linear stream in spread mode never stalls. The same stream in block mode stalls exactly two cycles per beat, and both figures can be checked as exact counter deltas. The small address space lets data written in one mode be read back through the other mode's aliased address, which exposes both bank/offset splits at the ports.

// File: rtl/bic_pkg.sv
package bic_pkg;

  // Per-cycle strobes from the control unit to the bank datapath
  typedef struct packed {
    logic issue;    // launch a request into the selected bank
    logic isWrite;  // the launched request is a write
    logic popRsp;   // the head read response leaves this cycle
  } bicStrobe_t;

endpackage

// File: rtl/bic_datapath.sv
module bic_datapath
  import bic_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int BANK_BITS   = 2,
  parameter int DATA_W      = 8,
  parameter int ACCESS_CYC  = 2,
  parameter int RECOVER_CYC = 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  bicStrobe_t                  strobe,
  input  logic [BANK_BITS-1:0]        issueBank,
  input  logic [ADDR_W-BANK_BITS-1:0] issueOffset,
  input  logic [DATA_W-1:0]           issueData,
  input  logic [BANK_BITS-1:0]        headBank,
  output logic [(1<<BANK_BITS)-1:0]   bankFree,
  output logic [(1<<BANK_BITS)-1:0]   resultValid,
  output logic [DATA_W-1:0]           rspData
);

  localparam int NB      = 1 << BANK_BITS;
  localparam int OFF_W   = ADDR_W - BANK_BITS;
  localparam int DEPTH   = 1 << OFF_W;
  localparam int SPAN    = ACCESS_CYC + RECOVER_CYC;
  localparam int CYC_W   = $clog2(SPAN + 1);
  localparam int DONE_AT = RECOVER_CYC + 1;

  logic [DATA_W-1:0] resultBus [NB];

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [CYC_W-1:0]  busyCnt;
    logic              opWrite;
    logic [OFF_W-1:0]  opOffset;
    logic [DATA_W-1:0] opData;
    logic [DATA_W-1:0] cells [DEPTH];
    logic [DATA_W-1:0] result;
    logic              resValid;
    logic              hit;
    logic              finish;
    logic              popHere;

    assign hit     = strobe.issue && (issueBank == BANK_BITS'(b));
    assign finish  = (busyCnt == CYC_W'(DONE_AT));
    assign popHere = strobe.popRsp && (headBank == BANK_BITS'(b));

    // Busy timer: loaded with the full cycle span, counts down to zero.
    // The bank may relaunch in the last cycle of its recovery.
    always_ff @(posedge clk) begin
      if (!rstN) begin
        busyCnt  <= '0;
        opWrite  <= 1'b0;
        opOffset <= '0;
        opData   <= '0;
        resValid <= 1'b0;
      end else begin
        if (hit) begin
          busyCnt  <= CYC_W'(SPAN);
          opWrite  <= strobe.isWrite;
          opOffset <= issueOffset;
          opData   <= issueData;
        end else if (busyCnt != '0) begin
          busyCnt <= busyCnt - CYC_W'(1);
        end
        resValid <= (resValid && !popHere) || (finish && !opWrite);
      end
    end

    // Storage and read capture at the end of the access phase
    always_ff @(posedge clk) begin
      if (finish && opWrite) begin
        cells[opOffset] <= opData;
      end
      if (finish && !opWrite) begin
        result <= cells[opOffset];
      end
    end

    assign bankFree[b]    = (busyCnt <= CYC_W'(1));
    assign resultValid[b] = resValid;
    assign resultBus[b]   = result;
  end

  assign rspData = resultBus[headBank];

endmodule

// File: rtl/bic_control.sv
module bic_control
  import bic_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int BANK_BITS = 2,
  parameter int TAG_DEPTH = 4,
  parameter int STALL_W   = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        modeHigh,
  input  logic                        reqValid,
  input  logic                        reqWrite,
  input  logic [ADDR_W-1:0]           reqAddr,
  input  logic [(1<<BANK_BITS)-1:0]   bankFree,
  input  logic [(1<<BANK_BITS)-1:0]   resultValid,
  output logic                        reqReady,
  output bicStrobe_t                  strobe,
  output logic [BANK_BITS-1:0]        issueBank,
  output logic [ADDR_W-BANK_BITS-1:0] issueOffset,
  output logic [BANK_BITS-1:0]        headBank,
  output logic                        rspValid,
  output logic [STALL_W-1:0]          stallCount,
  output logic                        modeLatched,
  output logic                        idleNow,
  output logic [$clog2(TAG_DEPTH):0]  pendingReads
);

  localparam int OFF_W = ADDR_W - BANK_BITS;
  localparam int PTR_W = $clog2(TAG_DEPTH);

  logic                 effMode;
  logic                 accept;
  logic                 push;
  logic                 pop;
  logic                 tagFull;
  logic                 conflict;
  logic [BANK_BITS-1:0] tagMem [TAG_DEPTH];
  logic [PTR_W-1:0]     wrPtr;
  logic [PTR_W-1:0]     rdPtr;
  logic [PTR_W:0]       tagCount;

  // Mode follows the input only while nothing is in flight
  assign idleNow = (&bankFree) && (tagCount == '0);
  assign effMode = idleNow ? modeHigh : modeLatched;

  always_ff @(posedge clk) begin
    if (!rstN) modeLatched <= 1'b0;
    else       modeLatched <= effMode;
  end

  // Address split for the two mappings
  always_comb begin
    if (effMode) begin
      issueBank   = reqAddr[ADDR_W-1 -: BANK_BITS];
      issueOffset = reqAddr[OFF_W-1:0];
    end else begin
      issueBank   = reqAddr[BANK_BITS-1:0];
      issueOffset = reqAddr[ADDR_W-1:BANK_BITS];
    end
  end

  assign tagFull  = (tagCount == (PTR_W+1)'(TAG_DEPTH));
  assign reqReady = bankFree[issueBank] && !(!reqWrite && tagFull);
  assign accept   = reqValid && reqReady;
  assign conflict = reqValid && !bankFree[issueBank];
  assign push     = accept && !reqWrite;

  // In-order tag queue of banks holding outstanding reads
  assign headBank = tagMem[rdPtr];
  assign rspValid = (tagCount != '0) && resultValid[headBank];
  assign pop      = rspValid;

  always_ff @(posedge clk) begin
    if (push) tagMem[wrPtr] <= issueBank;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      tagCount <= '0;
    end else begin
      if (push) wrPtr <= (wrPtr == PTR_W'(TAG_DEPTH-1)) ? '0 : wrPtr + PTR_W'(1);
      if (pop)  rdPtr <= (rdPtr == PTR_W'(TAG_DEPTH-1)) ? '0 : rdPtr + PTR_W'(1);
      case ({push, pop})
        2'b10:   tagCount <= tagCount + (PTR_W+1)'(1);
        2'b01:   tagCount <= tagCount - (PTR_W+1)'(1);
        default: tagCount <= tagCount;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)         stallCount <= '0;
    else if (conflict) stallCount <= stallCount + STALL_W'(1);
  end

  assign pendingReads = tagCount;

  always_comb begin
    strobe.issue   = accept;
    strobe.isWrite = reqWrite;
    strobe.popRsp  = pop;
  end

endmodule

// File: rtl/bank_interleave_ctrl.sv
module bank_interleave_ctrl
  import bic_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int BANK_BITS   = 2,
  parameter int DATA_W      = 8,
  parameter int ACCESS_CYC  = 2,
  parameter int RECOVER_CYC = 1,
  parameter int TAG_DEPTH   = 4,
  parameter int STALL_W     = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               modeHigh,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic               reqWrite,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [DATA_W-1:0]  reqWdata,
  output logic               rspValid,
  output logic [DATA_W-1:0]  rspData,
  output logic [STALL_W-1:0] stallCount
);

  localparam int NB    = 1 << BANK_BITS;
  localparam int OFF_W = ADDR_W - BANK_BITS;

  bicStrobe_t                  strobe;
  logic [BANK_BITS-1:0]        targetBank;
  logic [OFF_W-1:0]            targetOffset;
  logic [BANK_BITS-1:0]        headBank;
  logic [NB-1:0]               bankFree;
  logic [NB-1:0]               resultValid;
  logic                        modeLatched;
  logic                        idleNow;
  logic [$clog2(TAG_DEPTH):0]  pendingReads;

  bic_control #(
    .ADDR_W   (ADDR_W),
    .BANK_BITS(BANK_BITS),
    .TAG_DEPTH(TAG_DEPTH),
    .STALL_W  (STALL_W)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .modeHigh    (modeHigh),
    .reqValid    (reqValid),
    .reqWrite    (reqWrite),
    .reqAddr     (reqAddr),
    .bankFree    (bankFree),
    .resultValid (resultValid),
    .reqReady    (reqReady),
    .strobe      (strobe),
    .issueBank   (targetBank),
    .issueOffset (targetOffset),
    .headBank    (headBank),
    .rspValid    (rspValid),
    .stallCount  (stallCount),
    .modeLatched (modeLatched),
    .idleNow     (idleNow),
    .pendingReads(pendingReads)
  );

  bic_datapath #(
    .ADDR_W     (ADDR_W),
    .BANK_BITS  (BANK_BITS),
    .DATA_W     (DATA_W),
    .ACCESS_CYC (ACCESS_CYC),
    .RECOVER_CYC(RECOVER_CYC)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .issueBank  (targetBank),
    .issueOffset(targetOffset),
    .issueData  (reqWdata),
    .headBank   (headBank),
    .bankFree   (bankFree),
    .resultValid(resultValid),
    .rspData    (rspData)
  );

endmodule

// File: rtl/bic_checker.sv
module bic_checker #(
  parameter int BANK_BITS = 2,
  parameter int STALL_W   = 16,
  parameter int BUSY_SPAN = 3
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      reqValid,
  input logic                      reqReady,
  input logic                      reqWrite,
  input logic [BANK_BITS-1:0]      targetBank,
  input logic [(1<<BANK_BITS)-1:0] bankFree,
  input logic                      idleNow,
  input logic                      modeLatched,
  input logic [STALL_W-1:0]        stallCount
);

  // R4: a bank that just took a request is busy on the next cycle
  a_r4_busy_after_issue: assert property (@(posedge clk) disable iff (!rstN)
    (BUSY_SPAN > 1) && reqValid && reqReady |=> !bankFree[$past(targetBank)]);

  // R5: a write aimed at a free bank is always taken
  a_r5_free_write_ready: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqWrite && bankFree[targetBank] |-> reqReady);

  // R8: the latched mode cannot move while anything is in flight
  a_r8_mode_hold: assert property (@(posedge clk) disable iff (!rstN)
    !idleNow |=> $stable(modeLatched));

  // R9: one count per conflict cycle
  a_r9_stall_step: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !bankFree[targetBank] |=> stallCount == $past(stallCount) + STALL_W'(1));

  // R9: no count when the request is not held by a busy bank
  a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && !reqReady) |=> $stable(stallCount));

endmodule

bind bank_interleave_ctrl bic_checker #(
  .BANK_BITS(BANK_BITS),
  .STALL_W  (STALL_W),
  .BUSY_SPAN(ACCESS_CYC + RECOVER_CYC)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqReady   (reqReady),
  .reqWrite   (reqWrite),
  .targetBank (targetBank),
  .bankFree   (bankFree),
  .idleNow    (idleNow),
  .modeLatched(modeLatched),
  .stallCount (stallCount)
);

// File: tb/bank_interleave_ctrl_tb.sv
module bank_interleave_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 6;
  localparam int BANK_BITS  = 2;
  localparam int DATA_W     = 8;
  localparam int ACC        = 2;
  localparam int REC        = 1;
  localparam int SPAN       = ACC + REC;
  localparam int NVEC       = 16;

  // Row: {mode, write, addr[5:0], data[7:0]}
  localparam logic [15:0] VEC [NVEC] = '{
    {1'b0, 1'b1, 6'h00, 8'h11}, {1'b0, 1'b1, 6'h01, 8'h22},
    {1'b0, 1'b1, 6'h02, 8'h33}, {1'b0, 1'b1, 6'h03, 8'h44},
    {1'b0, 1'b1, 6'h05, 8'h55}, {1'b0, 1'b0, 6'h00, 8'h00},
    {1'b0, 1'b0, 6'h01, 8'h00}, {1'b0, 1'b0, 6'h02, 8'h00},
    {1'b0, 1'b0, 6'h03, 8'h00}, {1'b0, 1'b0, 6'h05, 8'h00},
    {1'b1, 1'b0, 6'h00, 8'h00}, {1'b1, 1'b0, 6'h10, 8'h00},
    {1'b1, 1'b0, 6'h20, 8'h00}, {1'b1, 1'b1, 6'h21, 8'h66},
    {1'b1, 1'b0, 6'h21, 8'h00}, {1'b0, 1'b0, 6'h06, 8'h00}
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              modeHigh = 1'b0;
  logic              reqValid = 1'b0;
  logic              reqReady;
  logic              reqWrite = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [DATA_W-1:0] reqWdata = '0;
  logic              rspValid;
  logic [DATA_W-1:0] rspData;
  logic [15:0]       stallCount;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic [DATA_W-1:0] model [64];
  logic [DATA_W-1:0] expData [$];
  int                expCyc [$];

  bank_interleave_ctrl u_dut (
    .clk(clk), .rstN(rstN), .modeHigh(modeHigh),
    .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspData(rspData), .stallCount(stallCount)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Physical slot from R1/R2
  function automatic int slotOf(input logic m, input logic [5:0] a);
    return m ? int'(a) : int'({a[1:0], a[5:2]});
  endfunction

  // Called at a negedge; returns at the negedge after acceptance
  task automatic issue(input logic w, input logic [5:0] a, input logic [7:0] d,
                       input logic m, output int acc);
    reqValid = 1'b1; reqWrite = w; reqAddr = a; reqWdata = d;
    #1;
    while (!reqReady) begin
      @(negedge clk); #1;
    end
    acc = cyc + 1;
    if (w) model[slotOf(m, a)] = d;
    else begin
      expData.push_back(model[slotOf(m, a)]);
      expCyc.push_back(acc);
    end
    @(negedge clk);
  endtask

  task automatic drain();
    reqValid = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  // Response monitor: R1/R2/R10 data, R7 order, R3 latency
  always @(negedge clk) begin
    if (rstN && rspValid) begin
      if (expData.size() == 0) chk(1'b0, "R7 unexpected response", 1, 0);
      else begin
        logic [7:0] e;
        int c;
        e = expData.pop_front();
        c = expCyc.pop_front();
        chk(rspData === e, "R1/R2/R7/R10 read data", int'(rspData), int'(e));
        chk(cyc - c == ACC, "R3 read latency", cyc - c, ACC);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int a0, a1, a2, a3, s0;
    logic prevMode;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11: reset state
    chk(reqReady === 1'b1, "R11 ready after reset", int'(reqReady), 1);
    chk(rspValid === 1'b0, "R11 no response after reset", int'(rspValid), 0);
    chk(stallCount === 16'd0, "R11 stall counter after reset", int'(stallCount), 0);

    // Table walk: R1, R2, R10 (write then read of 0x21), mode aliasing
    prevMode = 1'b0;
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][15] != prevMode) drain();
      prevMode = VEC[i][15];
      modeHigh = VEC[i][15];
      issue(VEC[i][14], VEC[i][13:8], VEC[i][7:0], VEC[i][15], a0);
    end
    drain();

    // R4: same bank back to back in block mode
    modeHigh = 1'b1;
    s0 = int'(stallCount);
    issue(1'b1, 6'h00, 8'hB0, 1'b1, a0);
    issue(1'b1, 6'h01, 8'hB1, 1'b1, a1);
    chk(a1 - a0 == SPAN, "R4 same-bank spacing", a1 - a0, SPAN);
    drain();
    chk(int'(stallCount) - s0 == SPAN - 1, "R9 stalls for one conflict", int'(stallCount) - s0, SPAN - 1);

    // R5: four distinct banks on consecutive edges
    s0 = int'(stallCount);
    issue(1'b1, 6'h00, 8'hC0, 1'b1, a0);
    issue(1'b1, 6'h10, 8'hC1, 1'b1, a1);
    issue(1'b1, 6'h20, 8'hC2, 1'b1, a2);
    issue(1'b1, 6'h30, 8'hC3, 1'b1, a3);
    chk(a3 - a0 == 3, "R5 distinct banks overlap", a3 - a0, 3);
    drain();
    chk(int'(stallCount) == s0, "R5 no stall across banks", int'(stallCount), s0);

    // R6: a blocked read holds back a later read to a free bank
    issue(1'b1, 6'h00, 8'hD0, 1'b1, a0);
    issue(1'b0, 6'h01, 8'h00, 1'b1, a1);
    issue(1'b0, 6'h10, 8'h00, 1'b1, a2);
    chk(a1 - a0 == SPAN, "R6 blocked read waits for bank", a1 - a0, SPAN);
    chk(a2 - a0 == SPAN + 1, "R6 later read not reordered", a2 - a0, SPAN + 1);
    drain();

    // R8: mode flipped while busy is ignored for in-flight traffic
    modeHigh = 1'b0;
    drain();
    issue(1'b1, 6'h01, 8'h77, 1'b0, a0);
    modeHigh = 1'b1;
    issue(1'b1, 6'h02, 8'h88, 1'b0, a1);
    drain();
    issue(1'b0, 6'h20, 8'h00, 1'b1, a0);  // R8: expects 0x88 via spread slot
    issue(1'b0, 6'h10, 8'h00, 1'b1, a0);  // R8: expects 0x77 via spread slot
    drain();

    // R9: linear stream, spread mode never stalls
    modeHigh = 1'b0;
    drain();
    s0 = int'(stallCount);
    for (int k = 0; k < 8; k++) issue(1'b1, 6'(k), 8'(k + 8'h40), 1'b0, a0);
    drain();
    chk(int'(stallCount) == s0, "R9 spread stream stalls", int'(stallCount) - s0, 0);

    // R9: linear stream, block mode stalls every beat
    modeHigh = 1'b1;
    drain();
    s0 = int'(stallCount);
    for (int k = 0; k < 4; k++) issue(1'b1, 6'(k), 8'(k + 8'h50), 1'b1, a0);
    drain();
    chk(int'(stallCount) - s0 == 3 * (SPAN - 1), "R9 block stream stalls",
        int'(stallCount) - s0, 3 * (SPAN - 1));

    // R7: every read answered
    chk(expData.size() == 0, "R7 outstanding reads left", expData.size(), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule